// File: doc/BRIEF.md
# Lockable Thermal Throttle Controller

This block holds an eight-bit thermal policy register that software writes over a simple single-cycle register bus. The register's fields are combined with two asynchronous thermal trip inputs, a hot trip and a catastrophic trip, to produce two throttle requests and a clock-halt request. One request throttles the controller and the other throttles the memory. The two trip inputs are resynchronised inside the block before any field acts on them.

Software first sets the policy: whether sensor-driven throttling is enabled, which throttle target is used, which trip levels start throttling, and whether a catastrophic trip halts the clocks. It can then set a sticky lock bit. After that, no write changes the register until hardware reset. A catastrophic trip under the halt policy latches the halt output, and only reset clears it.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset (active-low `rst_n` sampled at a clock edge), the register reads 0x00, both throttle outputs are 0 and `clk_halt_o` is 0.
- R2: Bits 5, 2 and 1 of the register always read 0, whatever value is written.
- R3: While the lock bit (bit 0) is 0, a write (`wr_en_i` high for one cycle) loads bits 7, 6, 4, 3 and 0 from `wr_data_i`. The new value is visible on `rd_data_o` in the next cycle. A write that sets bit 0 also loads the other writable bits in that same cycle.
- R4: Once bit 0 reads 1, every later write leaves all register bits unchanged. This includes a write of 0 to bit 0. Only reset clears the lock.
- R5: The trip inputs pass through two flip-flops. A trip input that changes before clock edge k affects the outputs after clock edge k+1.
- R6: When bit 7 (enable) is 0, both throttle outputs are 0 for every trip combination.
- R7: When bit 7 is 1, the trip condition is defined by bit 4. If bit 4 is 0, only a synchronised catastrophic trip counts. If bit 4 is 1, either a hot trip or a catastrophic trip counts.
- R8: When bit 7 is 1 and the trip condition is active, bit 6 routes the request. Bit 6 = 0 drives `thr_ctrl_o`; bit 6 = 1 drives `thr_dram_o`. The two outputs are never 1 together.
- R9: `clk_halt_o` rises one cycle after a synchronised catastrophic trip is seen while bit 3 is 1. It does not rise while bit 3 is 0.
- R10: Once `clk_halt_o` is set, it stays 1 until reset, even if the trip input or the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register value, reserved bits forced to 0 |
| trip_hot_i | input | 1 | Asynchronous hot trip |
| trip_cat_i | input | 1 | Asynchronous catastrophic trip |
| thr_ctrl_o | output | 1 | Controller throttle request |
| thr_dram_o | output | 1 | Memory throttle request |
| clk_halt_o | output | 1 | Latched clock-halt request |

## Verification
The bench sweeps all 256 write values through an unlocked register and checks the read-back. A design that stored the reserved bits, or dropped a field, would show it there. It also sweeps all enable, target and range settings against all four trip combinations. This catches a swapped target, a hot trip counted under the catastrophic-only policy, and any request issued while disabled. The lock is tested with the locking write itself, which must take effect, and then with later writes, including one that clears bit 0, which must be ignored. A design that blocked the locking write, or that let a lock be undone, fails these checks. The halt latch is checked before and after the catastrophic trip is removed and the register is rewritten, and is then reset. A design that made the halt combinational, or cleared it on a register change, fails these checks.

// File: rtl/thermal_throttle_pkg.sv
// Package: field positions and masks of the thermal policy register.
// Assumes an eight-bit register; positions are fixed because software decodes them.
package thermal_throttle_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned BIT_EN  = 7;   // master enable
    localparam int unsigned BIT_TGT = 6;   // 0 controller, 1 memory
    localparam int unsigned BIT_RNG = 4;   // 0 catastrophic only, 1 hot or catastrophic
    localparam int unsigned BIT_HLT = 3;   // halt on catastrophic
    localparam int unsigned BIT_LCK = 0;   // sticky lock
    localparam logic [REG_W-1:0] WR_MASK = 8'b1101_1001;

    typedef struct packed {
        logic enable;
        logic target_dram;
        logic range_hot;
        logic halt_cat;
    } policy_t;
endpackage

// File: rtl/trip_sync.sv
// Two-flop synchroniser for a bundle of independent trip levels.
// Assumes each bit is a slow level whose exact crossing cycle does not matter.
module trip_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] meta_q;

    // Capture the inputs and then re-register them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/policy_reg.sv
// Policy register with per-bit write mask and sticky self-lock.
// Assumes a single-cycle write strobe; the locking write itself still loads.
module policy_reg
    import thermal_throttle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] value_o,
    output thermal_throttle_pkg::policy_t policy_o
);
    logic [REG_W-1:0] reg_q;
    logic             locked;

    assign locked = reg_q[BIT_LCK];

    // Load writable bits while unlocked; reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_en_i && !locked) begin
            reg_q <= wr_data_i & WR_MASK;
        end
    end

    // Present the stored value with reserved bits forced to zero.
    always_comb begin
        value_o = reg_q & WR_MASK;
    end

    // Unpack fields for the decision logic.
    always_comb begin
        policy_o.enable      = reg_q[BIT_EN];
        policy_o.target_dram = reg_q[BIT_TGT];
        policy_o.range_hot   = reg_q[BIT_RNG];
        policy_o.halt_cat    = reg_q[BIT_HLT];
    end

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (reg_q == $past(reg_q)));
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (value_o & ~WR_MASK) == '0);
endmodule

// File: rtl/throttle_decide.sv
// Throttle routing and halt latch from the synchronised trips and policy.
// Assumes trips are already synchronous to clk.
module throttle_decide
    import thermal_throttle_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  thermal_throttle_pkg::policy_t policy_i,
    input  logic    hot_i,
    input  logic    cat_i,
    output logic    thr_ctrl_o,
    output logic    thr_dram_o,
    output logic    halt_o
);
    logic trip_active;

    // Pick which trips count and route the request to one target.
    always_comb begin
        trip_active = policy_i.enable && (cat_i || (policy_i.range_hot && hot_i));
        thr_ctrl_o  = trip_active && !policy_i.target_dram;
        thr_dram_o  = trip_active &&  policy_i.target_dram;
    end

    // Latch the halt on a catastrophic trip; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_o <= 1'b0;
        end else if (cat_i && policy_i.halt_cat) begin
            halt_o <= 1'b1;
        end
    end

    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({thr_ctrl_o, thr_dram_o}));
    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);
    // R9
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cat_i && policy_i.halt_cat) |=> halt_o);
    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !policy_i.enable |-> !(thr_ctrl_o || thr_dram_o));
endmodule

// File: rtl/thermal_throttle_ctrl.sv
// Top: lockable thermal policy register driving throttle requests and a halt latch.
// Assumes trip inputs are asynchronous levels and reset is synchronous active-low.
module thermal_throttle_ctrl
    import thermal_throttle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       trip_hot_i,
    input  logic       trip_cat_i,
    output logic       thr_ctrl_o,
    output logic       thr_dram_o,
    output logic       clk_halt_o
);
    logic [1:0] trip_s;
    thermal_throttle_pkg::policy_t policy;

    trip_sync #(.N(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({trip_cat_i, trip_hot_i}),
        .sync_o  (trip_s)
    );

    policy_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .value_o   (rd_data_o),
        .policy_o  (policy)
    );

    throttle_decide u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_i   (policy),
        .hot_i      (trip_s[0]),
        .cat_i      (trip_s[1]),
        .thr_ctrl_o (thr_ctrl_o),
        .thr_dram_o (thr_dram_o),
        .halt_o     (clk_halt_o)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o == 8'h00 && !clk_halt_o));
endmodule

// File: tb/thermal_throttle_ctrl_bench.sv
module thermal_throttle_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic hot = 1'b0, cat = 1'b0;
    logic [7:0] rd;
    logic tc, td, halt;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    thermal_throttle_ctrl u_thermal_throttle_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd), .trip_hot_i(hot), .trip_cat_i(cat),
        .thr_ctrl_o(tc), .thr_dram_o(td), .clk_halt_o(halt));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; hot = 0; cat = 0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Settle trips through both sync flops, then sample at negedge.
    task automatic set_trips(input logic h, input logic c);
        @(negedge clk); hot = h; cat = c;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        do_reset();
        chk("R1 reg", rd, 8'h00);
        chk("R1 outs", {5'b0, tc, td, halt}, 8'h00);

        // R2/R3 sweep of every write value while unlocked (bit0 kept 0)
        for (int v = 0; v < 256; v++) begin
            wr(8'(v) & 8'hFE);
            chk("R2 R3 readback", rd, 8'(v) & 8'hD8);
        end

        // R5 latency: enable, controller target, cat-only
        wr(8'h80);
        @(negedge clk); cat = 1;
        @(negedge clk);
        chk("R5 one edge", {7'b0, tc}, 8'h00);
        @(negedge clk);
        chk("R5 two edges", {7'b0, tc}, 8'h01);
        cat = 0; @(negedge clk); @(negedge clk);

        // R6/R7/R8 sweep of en, tgt, rng against all trips (halt off)
        for (int p = 0; p < 8; p++) begin
            logic en, tg, rg;
            en = p[2]; tg = p[1]; rg = p[0];
            wr({en, tg, 1'b0, rg, 4'b0});
            for (int t = 0; t < 4; t++) begin
                logic h, c, act;
                h = t[0]; c = t[1];
                set_trips(h, c);
                act = en && (c || (rg && h));
                chk("R6 R7 R8 ctrl", {7'b0, tc}, {7'b0, act && !tg});
                chk("R6 R7 R8 dram", {7'b0, td}, {7'b0, act && tg});
            end
            set_trips(0, 0);
        end
        chk("R9 no halt when bit3 clear", {7'b0, halt}, 8'h00);

        // R3/R4 locking write loads other bits, later writes ignored
        wr(8'hD9);
        chk("R3 locking write", rd, 8'hD9);
        wr(8'h00);
        chk("R4 write zero ignored", rd, 8'hD9);
        wr(8'h26);
        chk("R4 write ignored", rd, 8'hD9);

        // R9/R10 halt under lock (bit3 set)
        @(negedge clk); cat = 1;
        @(negedge clk); @(negedge clk);
        chk("R9 before latch", {7'b0, halt}, 8'h00);
        @(negedge clk);
        chk("R9 halt set", {7'b0, halt}, 8'h01);
        set_trips(0, 0);
        chk("R10 halt held", {7'b0, halt}, 8'h01);
        do_reset();
        chk("R1 lock cleared", rd, 8'h00);
        chk("R1 halt cleared", {7'b0, halt}, 8'h00);
        wr(8'h08);
        wr(8'h00);
        chk("R4 unlocked after reset", rd, 8'h00);
        wr(8'h08);
        set_trips(0, 1); @(negedge clk);
        wr(8'h00);
        chk("R10 held after reg change", {7'b0, halt}, 8'h01);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (100000) @(posedge clk); n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done"); end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule